// File: doc/BRIEF.md
# SD/MMC Multi-Lane Data Engine

This block carries block data between a byte-wide buffer port and the DAT lines of an SD or MMC card. Software selects a bus of one, four or eight lanes. On a write the engine frames each packet with a start cycle, serialises the bytes across the active lanes, appends a CRC16 that each lane computes over its own bits, and closes with an end cycle. It then releases the lanes, collects the card's three-bit write-status token on DAT0 and waits out the busy period. On a read it waits for the card's start bit, rebuilds bytes from the lanes, checks every active lane's CRC16 and raises a sticky error flag on any mismatch.

A packet is either one fixed-size block or a byte count that software chooses. A raw path lets the controller drive or sample the DAT lines directly, either for a single clock (one bit per lane) or for one byte at the selected width, with no framing and no CRC. One clock of `clk` is one bus bit-time. Command issue, clock generation and the buffer behind the byte port belong to neighbouring blocks.

Top module: `sd_lane_engine`

## Requirements
- R1: `width_sel` picks the lane count when an operation starts: 2'b00 gives one lane (DAT0), 2'b01 gives four lanes (DAT0..DAT3), 2'b10 gives eight lanes (DAT0..DAT7), and 2'b11 is treated as one lane. Lanes outside the selection are never driven (`dat_oe` bit 0), their inputs have no effect, and `dat_out` is 0 wherever `dat_oe` is 0.
- R2: A write (`start` with `wr_dir`=1) drives 0 on every active lane in the cycle after `start` is sampled. The data cycles follow, then 16 CRC cycles, then one cycle of 1 on every active lane, and after that `dat_oe` is 0.
- R3: Bytes go out MSB first. With one lane, DAT0 carries bits 7 down to 0 over eight cycles. With four lanes, two cycles are used: DATk carries bit 4+k in the first cycle and bit k in the second. With eight lanes, DATk carries bit k in a single cycle. Reads and raw byte operations use the same mapping.
- R4: Each active lane keeps its own CRC16 with polynomial x^16+x^12+x^5+1 (0x1021) and initial value 0, computed only over the data bits on that lane. It is sent MSB first in the CRC cycles.
- R5: A packet holds BLOCK_BYTES bytes (default 512) when `unit_blk`=1, and `byte_len` bytes (at least 1) otherwise. `tx_req` is 1 in the cycle whose closing edge takes `tx_data`: the start-bit cycle, and the last cycle of every byte except the final one.
- R6: After the release, the engine waits for a 0 on DAT0. It shifts the next three DAT0 bits, MSB first, into `wstat` and skips one end bit. It then stays busy while DAT0 is 0. `done` pulses in the cycle after DAT0 is sampled 1, and `wstat_ok` is 1 when `wstat` is 3'b010.
- R7: A read (`start` with `wr_dir`=0) waits for a 0 on DAT0. It then samples the data cycles and presents each byte on `rx_data`, with `rx_valid` high for one cycle, in the cycle after that byte's last bit. After the data come 16 CRC cycles and one end cycle, and `done` pulses in the cycle after the end cycle.
- R8: When the received CRC of any active lane disagrees with the CRC computed over that lane's data, `crc_err` becomes 1 in the `done` cycle. It stays 1 through later operations until a cycle with `crc_clr`=1, after which it reads 0.
- R9: A raw bit operation (`raw_go` with `raw_bit`=1) lasts one cycle. If `raw_wr`=1, `raw_wdata` is driven on the active lanes. The active lanes of `dat_in` are sampled at the end of that cycle into `raw_rdata`, inactive bits read 0, and `done` pulses in the next cycle.
- R10: A raw byte operation (`raw_go` with `raw_bit`=0) spends 8, 2 or 1 cycles at widths 1, 4 or 8. With `raw_wr`=1 it drives `raw_wdata` using the R3 mapping, with no start bit, CRC or end bit. It collects the lanes into `raw_rdata` using the same mapping, and `done` pulses in the cycle after its last bit.
- R11: After reset, `dat_oe`, `tx_req`, `rx_valid`, `busy`, `done` and `crc_err` are all 0.
- R12: `busy` is 1 from the cycle after an operation is accepted until its `done` cycle. In the `done` cycle it is 0 and `done` is 1, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_sel | input | 2 | Lane count select |
| start | input | 1 | Begin a packet transfer (when idle) |
| wr_dir | input | 1 | 1 = write to card, 0 = read from card |
| unit_blk | input | 1 | 1 = fixed block length, 0 = `byte_len` bytes |
| byte_len | input | LEN_W | Byte count for byte-unit transfers |
| tx_data | input | 8 | Next byte to write |
| tx_req | output | 1 | `tx_data` is taken at the coming edge |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_data` holds a new byte |
| raw_go | input | 1 | Begin a raw operation (when idle) |
| raw_bit | input | 1 | 1 = single bit-time, 0 = one byte |
| raw_wr | input | 1 | Raw operation drives the lanes |
| raw_wdata | input | 8 | Raw data to drive |
| raw_rdata | output | 8 | Raw data sampled |
| dat_out | output | 8 | DAT lane output values |
| dat_oe | output | 8 | DAT lane output enables |
| dat_in | input | 8 | DAT lane input values |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| crc_err | output | 1 | Sticky read CRC mismatch flag |
| crc_clr | input | 1 | Clear `crc_err` |
| wstat | output | 3 | Last write-status token |
| wstat_ok | output | 1 | Token signals acceptance |

## Verification
Every output is a register or decodes registers, so each result appears in the cycle after the edge that produced it. The start bit comes one cycle after `start`. A received byte shows up one cycle after its last bit. `done` arrives one cycle after the end cycle of a read, or one cycle after DAT0 is first sampled high in a write's busy phase, and a raw result one cycle after its last bit-time. For every operation the bench lays out a per-cycle table of expected lane values, requests, strobes and input drive, counted from the edge that accepts the command. It drives and compares at the falling edge of each cycle, so every comparison falls one half-period after the edge that makes the value due.

// File: rtl/sd_lane_pkg.sv
package sd_lane_pkg;
    localparam int LANES = 8;
    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [2:0] TOKEN_OK = 3'b010;

    typedef enum logic [1:0] {
        BW_1   = 2'b00,
        BW_4   = 2'b01,
        BW_8   = 2'b10,
        BW_RSV = 2'b11
    } bus_w_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_START,
        ST_W_DATA,
        ST_W_CRC,
        ST_W_END,
        ST_W_STAT,
        ST_W_BUSY,
        ST_R_WAIT,
        ST_R_DATA,
        ST_R_CRC,
        ST_R_END,
        ST_RAW
    } eng_state_e;
endpackage

// File: rtl/sd_crc16_bank.sv
module sd_crc16_bank
    import sd_lane_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int W = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               upd,
    input  logic               shift,
    input  logic [N_LANES-1:0] bits_in,
    output logic [N_LANES-1:0] msb,
    output logic [N_LANES-1:0] zero
);
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [W-1:0] crc_d, crc_q;

        always_comb begin
            crc_d = crc_q;
            if (clr) begin
                crc_d = '0;
            end else if (upd) begin
                crc_d = {crc_q[W-2:0], 1'b0};
                if (bits_in[g] ^ crc_q[W-1]) begin
                    crc_d = crc_d ^ POLY;
                end
            end else if (shift) begin
                crc_d = {crc_q[W-2:0], 1'b0};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) crc_q <= '0;
            else        crc_q <= crc_d;
        end

        assign msb[g]  = crc_q[W-1];
        assign zero[g] = (crc_q == '0);

        assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> zero[g]);
    end
endmodule

// File: rtl/sd_lane_map.sv
module sd_lane_map
    import sd_lane_pkg::*;
(
    input  bus_w_e     bw,
    input  logic [2:0] ph,
    input  logic [7:0] tx_byte,
    input  logic [7:0] rx_shift,
    input  logic [7:0] lanes_in,
    output logic [7:0] lane_bits,
    output logic [7:0] lane_mask,
    output logic [7:0] rx_next,
    output logic [2:0] last_ph
);
    always_comb begin
        case (bw)
            BW_4: begin
                lane_mask = 8'h0F;
                last_ph   = 3'd1;
                lane_bits = {4'b0000, ph[0] ? tx_byte[3:0] : tx_byte[7:4]};
                rx_next   = {rx_shift[3:0], lanes_in[3:0]};
            end
            BW_8: begin
                lane_mask = 8'hFF;
                last_ph   = 3'd0;
                lane_bits = tx_byte;
                rx_next   = lanes_in;
            end
            default: begin
                lane_mask = 8'h01;
                last_ph   = 3'd7;
                lane_bits = {7'b0000000, tx_byte[3'd7 - ph]};
                rx_next   = {rx_shift[6:0], lanes_in[0]};
            end
        endcase
    end
endmodule

// File: rtl/sd_lane_engine.sv
module sd_lane_engine
    import sd_lane_pkg::*;
#(
    parameter int LEN_W       = 10,
    parameter int BLOCK_BYTES = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       width_sel,
    input  logic             start,
    input  logic             wr_dir,
    input  logic             unit_blk,
    input  logic [LEN_W-1:0] byte_len,
    input  logic [7:0]       tx_data,
    output logic             tx_req,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    input  logic             raw_go,
    input  logic             raw_bit,
    input  logic             raw_wr,
    input  logic [7:0]       raw_wdata,
    output logic [7:0]       raw_rdata,
    output logic [7:0]       dat_out,
    output logic [7:0]       dat_oe,
    input  logic [7:0]       dat_in,
    output logic             busy,
    output logic             done,
    output logic             crc_err,
    input  logic             crc_clr,
    output logic [2:0]       wstat,
    output logic             wstat_ok
);
    localparam int CNT_W = $clog2(CRC_W) + 1;
    localparam logic [LEN_W-1:0] BLK_LEN  = LEN_W'(BLOCK_BYTES);
    localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(CRC_W - 1);
    localparam logic [CNT_W-1:0] TOK_END  = CNT_W'(4);

    typedef struct packed {
        eng_state_e       st;
        bus_w_e           bw;
        logic             r_bit;
        logic             r_wr;
        logic [2:0]       ph;
        logic [LEN_W-1:0] left;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sbyte;
        logic [7:0]       shreg;
        logic [2:0]       wst;
        logic [7:0]       rxd;
        logic             rxv;
        logic             dn;
        logic             err;
        logic [7:0]       rawd;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    logic [7:0] lane_bits, lane_mask, rx_next;
    logic [2:0] last_ph;
    logic [7:0] crc_msb, crc_zero;
    logic       bank_clr, bank_upd, bank_shift;
    logic [7:0] bank_bits;
    logic [7:0] oe_c, out_c;
    bus_w_e     bw_in;
    logic [LEN_W-1:0] len_m1;
    logic       last_cyc;

    sd_lane_map u_map (
        .bw        (r_q.bw),
        .ph        (r_q.ph),
        .tx_byte   (r_q.sbyte),
        .rx_shift  (r_q.shreg),
        .lanes_in  (dat_in),
        .lane_bits (lane_bits),
        .lane_mask (lane_mask),
        .rx_next   (rx_next),
        .last_ph   (last_ph)
    );

    sd_crc16_bank #(.N_LANES(LANES)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (bank_clr),
        .upd     (bank_upd),
        .shift   (bank_shift),
        .bits_in (bank_bits),
        .msb     (crc_msb),
        .zero    (crc_zero)
    );

    assign bw_in    = (width_sel == 2'b11) ? BW_1 : bus_w_e'(width_sel);
    assign len_m1   = (unit_blk ? BLK_LEN : byte_len) - 1'b1;
    assign last_cyc = (r_q.ph == last_ph);

    assign bank_clr   = (r_q.st == ST_IDLE) && start;
    assign bank_upd   = (r_q.st == ST_W_DATA) || (r_q.st == ST_R_DATA) ||
                        (r_q.st == ST_R_CRC);
    assign bank_shift = (r_q.st == ST_W_CRC);
    assign bank_bits  = ((r_q.st == ST_W_DATA) ? lane_bits : dat_in) & lane_mask;

    always_comb begin
        r_d     = r_q;
        r_d.dn  = 1'b0;
        r_d.rxv = 1'b0;
        if (crc_clr) r_d.err = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.bw   = bw_in;
                    r_d.st   = wr_dir ? ST_W_START : ST_R_WAIT;
                    r_d.left = len_m1;
                    r_d.ph   = '0;
                    r_d.cnt  = '0;
                end else if (raw_go) begin
                    r_d.bw    = bw_in;
                    r_d.st    = ST_RAW;
                    r_d.r_bit = raw_bit;
                    r_d.r_wr  = raw_wr;
                    r_d.sbyte = raw_wdata;
                    r_d.ph    = '0;
                    r_d.shreg = '0;
                end
            end
            ST_W_START: begin
                r_d.sbyte = tx_data;
                r_d.ph    = '0;
                r_d.st    = ST_W_DATA;
            end
            ST_W_DATA: begin
                if (last_cyc) begin
                    r_d.ph = '0;
                    if (r_q.left == '0) begin
                        r_d.st  = ST_W_CRC;
                        r_d.cnt = '0;
                    end else begin
                        r_d.sbyte = tx_data;
                        r_d.left  = r_q.left - 1'b1;
                    end
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            ST_W_CRC: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CRC_LAST) r_d.st = ST_W_END;
            end
            ST_W_END: begin
                r_d.st  = ST_W_STAT;
                r_d.cnt = '0;
            end
            ST_W_STAT: begin
                if (r_q.cnt == '0) begin
                    if (!dat_in[0]) r_d.cnt = 1;
                end else if (r_q.cnt == TOK_END) begin
                    r_d.st = ST_W_BUSY;
                end else begin
                    r_d.wst = {r_q.wst[1:0], dat_in[0]};
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_W_BUSY: begin
                if (dat_in[0]) begin
                    r_d.st = ST_IDLE;
                    r_d.dn = 1'b1;
                end
            end
            ST_R_WAIT: begin
                if (!dat_in[0]) begin
                    r_d.st    = ST_R_DATA;
                    r_d.ph    = '0;
                    r_d.shreg = '0;
                end
            end
            ST_R_DATA: begin
                r_d.shreg = rx_next;
                if (last_cyc) begin
                    r_d.rxd = rx_next;
                    r_d.rxv = 1'b1;
                    r_d.ph  = '0;
                    if (r_q.left == '0) begin
                        r_d.st  = ST_R_CRC;
                        r_d.cnt = '0;
                    end else begin
                        r_d.left = r_q.left - 1'b1;
                    end
                end else begin
                    r_d.ph = r_q.ph + 1'b1;
                end
            end
            ST_R_CRC: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CRC_LAST) r_d.st = ST_R_END;
            end
            ST_R_END: begin
                if (|(~crc_zero & lane_mask)) r_d.err = 1'b1;
                r_d.st = ST_IDLE;
                r_d.dn = 1'b1;
            end
            ST_RAW: begin
                if (r_q.r_bit) begin
                    r_d.rawd = dat_in & lane_mask;
                    r_d.st   = ST_IDLE;
                    r_d.dn   = 1'b1;
                end else begin
                    r_d.shreg = rx_next;
                    if (last_cyc) begin
                        r_d.rawd = rx_next;
                        r_d.st   = ST_IDLE;
                        r_d.dn   = 1'b1;
                    end else begin
                        r_d.ph = r_q.ph + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        oe_c  = 8'h00;
        out_c = 8'h00;
        case (r_q.st)
            ST_W_START: oe_c = lane_mask;
            ST_W_DATA: begin
                oe_c  = lane_mask;
                out_c = lane_bits;
            end
            ST_W_CRC: begin
                oe_c  = lane_mask;
                out_c = crc_msb;
            end
            ST_W_END: begin
                oe_c  = lane_mask;
                out_c = 8'hFF;
            end
            ST_RAW: begin
                if (r_q.r_wr) begin
                    oe_c  = lane_mask;
                    out_c = r_q.r_bit ? r_q.sbyte : lane_bits;
                end
            end
            default: ;
        endcase
    end

    assign dat_oe    = oe_c;
    assign dat_out   = out_c & oe_c;
    assign tx_req    = (r_q.st == ST_W_START) ||
                       ((r_q.st == ST_W_DATA) && last_cyc && (r_q.left != '0));
    assign rx_data   = r_q.rxd;
    assign rx_valid  = r_q.rxv;
    assign raw_rdata = r_q.rawd;
    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.dn;
    assign crc_err   = r_q.err;
    assign wstat     = r_q.wst;
    assign wstat_ok  = (r_q.wst == TOKEN_OK);

    assert_oe_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_oe == 8'h00) || (dat_oe == 8'h01) || (dat_oe == 8'h0F) || (dat_oe == 8'hFF));

    assert_release_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_W_END) |=> (dat_oe == 8'h00));

    assert_txreq_while_driving_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (dat_oe != 8'h00));

    assert_rx_not_driving_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (dat_oe == 8'h00));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err && !crc_clr) |=> crc_err);

    assert_raw_bit_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_RAW) && r_q.r_bit) |=> done);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/sd_lane_engine_bench.sv
module sd_lane_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 10;
    localparam int BLK = 512;
    localparam int MAXC = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] width_sel = 2'b00;
    logic start = 1'b0, wr_dir = 1'b0, unit_blk = 1'b0;
    logic [LEN_W-1:0] byte_len = '0;
    logic [7:0] tx_data = 8'h00;
    logic tx_req, rx_valid;
    logic [7:0] rx_data;
    logic raw_go = 1'b0, raw_bit = 1'b0, raw_wr = 1'b0;
    logic [7:0] raw_wdata = 8'h00;
    logic [7:0] raw_rdata, dat_out, dat_oe;
    logic [7:0] dat_in = 8'hFF;
    logic busy, done, crc_err;
    logic crc_clr = 1'b0;
    logic [2:0] wstat;
    logic wstat_ok;

    int tests = 0;
    int fails = 0;

    logic [7:0] e_oe  [0:MAXC];
    logic [7:0] e_out [0:MAXC];
    logic [7:0] e_rxd [0:MAXC];
    logic [7:0] d_in  [0:MAXC];
    bit         e_txr [0:MAXC];
    bit         e_rxv [0:MAXC];
    string      e_tag [0:MAXC];
    int         ncyc;
    logic [7:0] bytes_q [0:1023];

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_lane_engine #(.LEN_W(LEN_W), .BLOCK_BYTES(BLK)) u_sd_lane_engine (
        .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .start(start),
        .wr_dir(wr_dir), .unit_blk(unit_blk), .byte_len(byte_len),
        .tx_data(tx_data), .tx_req(tx_req), .rx_data(rx_data), .rx_valid(rx_valid),
        .raw_go(raw_go), .raw_bit(raw_bit), .raw_wr(raw_wr), .raw_wdata(raw_wdata),
        .raw_rdata(raw_rdata), .dat_out(dat_out), .dat_oe(dat_oe), .dat_in(dat_in),
        .busy(busy), .done(done), .crc_err(crc_err), .crc_clr(crc_clr),
        .wstat(wstat), .wstat_ok(wstat_ok)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lanes_of(input logic [1:0] code);
        return (code == 2'b01) ? 4 : (code == 2'b10) ? 8 : 1;
    endfunction

    function automatic logic [7:0] mask_of(input int w);
        return (w == 8) ? 8'hFF : (w == 4) ? 8'h0F : 8'h01;
    endfunction

    function automatic int phases(input int w);
        return 8 / w;
    endfunction

    // R3 bit placement
    function automatic logic [7:0] lbits(input int w, input logic [7:0] b, input int ph);
        if (w == 8) return b;
        if (w == 4) return (ph == 0) ? {4'h0, b[7:4]} : {4'h0, b[3:0]};
        return {7'd0, b[7-ph]};
    endfunction

    // R4 per-lane CRC16 step, polynomial 0x1021
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic [15:0] n;
        n = {c[14:0], 1'b0};
        if (b ^ c[15]) n = n ^ 16'h1021;
        return n;
    endfunction

    task automatic clear_exp();
        for (int c = 0; c <= MAXC; c++) begin
            e_oe[c] = 8'h00; e_out[c] = 8'h00; e_rxd[c] = 8'h00; d_in[c] = 8'hFF;
            e_txr[c] = 1'b0; e_rxv[c] = 1'b0; e_tag[c] = "R12";
        end
    endtask

    task automatic prep_write(input int w, input int len, input logic [2:0] tok, input int bsy);
        logic [15:0] cr [8];
        logic [7:0] m, lb, ob;
        int p, c;
        clear_exp();
        m = mask_of(w); p = phases(w);
        for (int l = 0; l < 8; l++) cr[l] = 16'h0000;
        e_oe[1] = m; e_out[1] = 8'h00; e_txr[1] = 1'b1; e_tag[1] = "R2";
        for (int k = 0; k < len; k++) begin
            for (int ph = 0; ph < p; ph++) begin
                c = 2 + k * p + ph;
                lb = lbits(w, bytes_q[k], ph);
                e_oe[c] = m; e_out[c] = lb & m; e_tag[c] = "R3";
                if (ph == p - 1 && k < len - 1) e_txr[c] = 1'b1;
                for (int l = 0; l < 8; l++) cr[l] = crc_step(cr[l], lb[l]);
            end
        end
        for (int i = 0; i < 16; i++) begin
            c = 2 + len * p + i;
            for (int l = 0; l < 8; l++) ob[l] = cr[l][15-i];
            e_oe[c] = m; e_out[c] = ob & m; e_tag[c] = "R4";
        end
        c = 18 + len * p;
        e_oe[c] = m; e_out[c] = m; e_tag[c] = "R2";
        c = 19 + len * p;
        for (int i = c; i < c + 7 + bsy; i++) e_tag[i] = "R6";
        d_in[c + 2] = 8'hFE;
        d_in[c + 3] = {7'h7F, tok[2]};
        d_in[c + 4] = {7'h7F, tok[1]};
        d_in[c + 5] = {7'h7F, tok[0]};
        for (int i = 0; i < bsy; i++) d_in[c + 7 + i] = 8'hFE;
        ncyc = 27 + bsy + len * p;
    endtask

    task automatic prep_read(input int w, input int len, input int bad_lane, input bit junk);
        logic [15:0] cr [8];
        logic [7:0] m, lb, ob, jk;
        int p, c;
        clear_exp();
        m = mask_of(w); p = phases(w);
        for (int l = 0; l < 8; l++) cr[l] = 16'h0000;
        d_in[3] = junk ? (8'hA4 & ~m) : ~m;
        for (int k = 0; k < len; k++) begin
            for (int ph = 0; ph < p; ph++) begin
                c = 4 + k * p + ph;
                lb = lbits(w, bytes_q[k], ph);
                jk = junk ? (8'(c * 37) & ~m) : ~m;
                d_in[c] = (lb & m) | jk;
                e_tag[c] = "R7";
                for (int l = 0; l < 8; l++) cr[l] = crc_step(cr[l], lb[l]);
            end
            e_rxv[4 + (k + 1) * p] = 1'b1;
            e_rxd[4 + (k + 1) * p] = bytes_q[k];
        end
        for (int i = 0; i < 16; i++) begin
            c = 4 + len * p + i;
            for (int l = 0; l < 8; l++) ob[l] = cr[l][15-i];
            if (bad_lane >= 0 && i == 5) ob[bad_lane] = ~ob[bad_lane];
            jk = junk ? (8'(c * 53) & ~m) : ~m;
            d_in[c] = (ob & m) | jk;
            e_tag[c] = "R4";
        end
        ncyc = 21 + len * p;
    endtask

    task automatic prep_raw_bit(input int w, input bit wr, input logic [7:0] wd, input logic [7:0] di);
        clear_exp();
        e_oe[1]  = wr ? mask_of(w) : 8'h00;
        e_out[1] = wr ? (wd & mask_of(w)) : 8'h00;
        d_in[1]  = di;
        e_tag[1] = "R9";
        ncyc = 2;
    endtask

    task automatic prep_raw_byte(input int w, input bit wr, input logic [7:0] wd, input logic [7:0] rb);
        int p;
        clear_exp();
        p = phases(w);
        for (int ph = 0; ph < p; ph++) begin
            e_oe[ph + 1]  = wr ? mask_of(w) : 8'h00;
            e_out[ph + 1] = wr ? lbits(w, wd, ph) : 8'h00;
            d_in[ph + 1]  = lbits(w, rb, ph) | ~mask_of(w);
            e_tag[ph + 1] = "R10";
        end
        ncyc = p + 1;
    endtask

    task automatic go(input bit is_raw);
        int txk;
        txk = 0;
        @(negedge clk);
        if (is_raw) raw_go = 1'b1; else start = 1'b1;
        for (int c = 1; c <= ncyc; c++) begin
            @(negedge clk);
            start = 1'b0; raw_go = 1'b0;
            dat_in = d_in[c];
            if (e_txr[c]) begin
                tx_data = bytes_q[txk];
                txk++;
            end
            check((dat_oe === e_oe[c]) && ((dat_out & dat_oe) === e_out[c]),
                  e_tag[c], {dat_oe, dat_out}, {e_oe[c], e_out[c]});
            check(tx_req === e_txr[c], "R5", tx_req, e_txr[c]);
            check((done === (c == ncyc)) && (busy === (c != ncyc)), "R12",
                  {done, busy}, {(c == ncyc), (c != ncyc)});
            check((rx_valid === e_rxv[c]) && (!e_rxv[c] || rx_data === e_rxd[c]),
                  "R7", {rx_valid, rx_data}, {e_rxv[c], e_rxd[c]});
        end
        dat_in = 8'hFF;
    endtask

    task automatic set_op(input logic [1:0] ws, input bit wr, input bit ub, input int len);
        width_sel = ws; wr_dir = wr; unit_blk = ub; byte_len = LEN_W'(len);
    endtask

    task automatic fill(input int n, input int seed);
        for (int i = 0; i < n; i++) bytes_q[i] = 8'((i * seed + 8'h5D) ^ (i >> 2));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int w, n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check((dat_oe === 8'h00) && (tx_req === 1'b0) && (rx_valid === 1'b0),
              "R11", {dat_oe, tx_req, rx_valid}, 0);
        check((busy === 1'b0) && (done === 1'b0) && (crc_err === 1'b0),
              "R11", {busy, done, crc_err}, 0);

        // R2 R3 R4 R6: one-lane byte write, accepted token
        bytes_q[0] = 8'hA5; bytes_q[1] = 8'h3C; bytes_q[2] = 8'h81;
        set_op(2'b00, 1'b1, 1'b0, 3);
        prep_write(1, 3, 3'b010, 2);
        go(1'b0);
        check((wstat === 3'b010) && (wstat_ok === 1'b1), "R6", {wstat, wstat_ok}, {3'b010, 1'b1});

        // R6: four-lane write, rejected token, no busy period
        fill(4, 29);
        set_op(2'b01, 1'b1, 1'b0, 4);
        prep_write(4, 4, 3'b101, 0);
        go(1'b0);
        check((wstat === 3'b101) && (wstat_ok === 1'b0), "R6", {wstat, wstat_ok}, {3'b101, 1'b0});

        // R5: eight-lane block write of BLOCK_BYTES
        fill(BLK, 7);
        byte_len = LEN_W'(3);
        set_op(2'b10, 1'b1, 1'b1, 3);
        prep_write(8, BLK, 3'b010, 5);
        go(1'b0);
        check(wstat_ok === 1'b1, "R5", wstat_ok, 1);

        // R1: reserved width code behaves as one lane
        fill(2, 13);
        set_op(2'b11, 1'b1, 1'b0, 2);
        prep_write(1, 2, 3'b010, 1);
        go(1'b0);

        // R7 R1: one-lane read with noise on the unused lanes, no error
        fill(2, 41);
        set_op(2'b00, 1'b0, 1'b0, 2);
        prep_read(1, 2, -1, 1'b1);
        go(1'b0);
        check(crc_err === 1'b0, "R1", crc_err, 0);

        // R7: four-lane read, clean
        fill(5, 19);
        set_op(2'b01, 1'b0, 1'b0, 5);
        prep_read(4, 5, -1, 1'b0);
        go(1'b0);
        check(crc_err === 1'b0, "R8", crc_err, 0);

        // R8: eight-lane read with a bad CRC bit on lane 5
        fill(3, 11);
        set_op(2'b10, 1'b0, 1'b0, 3);
        prep_read(8, 3, 5, 1'b0);
        go(1'b0);
        check(crc_err === 1'b1, "R8", crc_err, 1);

        // R8 sticky across a clean four-lane block read
        fill(BLK, 3);
        set_op(2'b01, 1'b0, 1'b1, 1);
        prep_read(4, BLK, -1, 1'b0);
        go(1'b0);
        check(crc_err === 1'b1, "R8", crc_err, 1);

        @(negedge clk); crc_clr = 1'b1;
        @(negedge clk); crc_clr = 1'b0;
        check(crc_err === 1'b0, "R8", crc_err, 0);

        // R8: one-lane read with a bad CRC on lane 0
        fill(2, 23);
        set_op(2'b00, 1'b0, 1'b0, 2);
        prep_read(1, 2, 0, 1'b0);
        go(1'b0);
        check(crc_err === 1'b1, "R8", crc_err, 1);
        @(negedge clk); crc_clr = 1'b1;
        @(negedge clk); crc_clr = 1'b0;
        check(crc_err === 1'b0, "R8", crc_err, 0);

        // R9: raw bit operations
        raw_bit = 1'b1; raw_wr = 1'b1; raw_wdata = 8'hA6; width_sel = 2'b01;
        prep_raw_bit(4, 1'b1, 8'hA6, 8'h5B);
        go(1'b1);
        check(raw_rdata === 8'h0B, "R9", raw_rdata, 8'h0B);

        raw_wr = 1'b0; width_sel = 2'b10;
        prep_raw_bit(8, 1'b0, 8'hA6, 8'hC7);
        go(1'b1);
        check(raw_rdata === 8'hC7, "R9", raw_rdata, 8'hC7);

        // R10: raw byte operations at each width
        for (int i = 0; i < 3; i++) begin
            w = (i == 0) ? 1 : (i == 1) ? 4 : 8;
            n = (i == 0) ? 8'h96 : (i == 1) ? 8'h5E : 8'hE1;
            raw_bit = 1'b0; raw_wr = (i != 1);
            raw_wdata = (i == 0) ? 8'hC3 : 8'h3A;
            width_sel = (i == 0) ? 2'b00 : (i == 1) ? 2'b01 : 2'b10;
            prep_raw_byte(w, raw_wr, raw_wdata, 8'(n));
            go(1'b1);
            check(raw_rdata === 8'(n), "R10", raw_rdata, n);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule